// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static memory organised as words of byte lanes. Each lane is nine bits wide: eight data bits and one parity bit, both stored and returned as ordinary data. Address, write data and write controls are captured on the rising clock edge. A selected cycle is either a read or a write. Reads deliver the addressed word from an output register one clock after the address is captured.

Writes use two levels of gating. A global write strobe covers every lane. Otherwise a byte-write enable qualifies one strobe per lane, so any subset of lanes can be updated. Internally a write is posted into a one-entry buffer and is committed to the array when the next write arrives. Reads merge the buffered lanes over the array contents, so a word written in one cycle can be read back in the very next cycle. The output enable is combinational and masks the data. A deselect leaves the output driven for one extra stage before it is released.

Top module: `sync_sram_core`

## Requirements
- R1: While reset is asserted, and until the first read completes, `rvalid` is 0 and `rdata` is all zeros.
- R2: With `cs_n` low and `gw_n` low, every lane of the addressed word is written from `wdata`, whatever `bwe_n` and `bw_n` are.
- R3: With `cs_n` low, `gw_n` high and `bwe_n` low, lane i is written exactly when `bw_n[i]` is low, and the other lanes keep their contents. Lane i occupies `wdata`/`rdata` bits [9i+8:9i], and bit 9i+8 is its parity bit. With `bwe_n` high, the lane strobes have no effect.
- R4: A cycle with `bwe_n` low, `gw_n` high and every `bw_n` bit high is a write cycle that changes no lane.
- R5: A cycle with `cs_n` low, `gw_n` high and `bwe_n` high is a read. If its inputs are set up before rising edge e, the addressed word is on `rdata` with `rvalid` high after edge e+1, provided `oe_n` is low.
- R6: A read issued in the cycle right after a write to the same address returns the newly written lanes, merged with the untouched lanes.
- R7: `oe_n` high forces `rvalid` to 0 and `rdata` to zero at once, without a clock edge. Lowering `oe_n` brings back the held word at once.
- R8: When a deselect (`cs_n` high) is captured at edge j, the output still holds its previous state after edge j+1. If the cycle captured at edge j+1 is also a deselect, `rvalid` is 0 after edge j+2.
- R9: A selected write captured at edge e makes `rvalid` 0 after edge e+1.
- R10: A write attempted while `cs_n` is high leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| addr | input | AW (6) | Word address |
| wdata | input | L*LW (36) | Write data, lane i at bits [9i+8:9i] |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low, qualifies `bw_n` |
| bw_n | input | L (4) | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | L*LW (36) | Read data, zero when not driven |
| rvalid | output | 1 | High while `rdata` is driven |

## Verification
A corrupted write mask or a stale buffer entry stays invisible until that address is read. The error then shows as wrong lanes on `rdata` two edges after the read is issued. The bench therefore reads back every address after the write patterns, and it issues many reads right after writes to the same small set of addresses. A fault in the drive/deselect state shows as `rvalid` changing one edge early or late around deselects and writes, and it can be seen in the cycle that follows. A fault in the output-enable gating shows within the same cycle, with no clock edge.

// File: rtl/sram_pkg.sv
package sram_pkg;
  // Operation held in the input register stage
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int L  = 4,
  parameter int LW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [AW-1:0]     addr,
  input  logic [L*LW-1:0]   wdata,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [L-1:0]      bw_n,
  output sram_op_e          op_q,
  output logic [AW-1:0]     addr_q,
  output logic [L*LW-1:0]   wdata_q,
  output logic [L-1:0]      mask_q
);
  logic [L-1:0] lane_en;
  sram_op_e     op_d;
  logic         cap_en;

  // Two-level write gating per lane
  for (genvar g = 0; g < L; g++) begin : g_lane
    assign lane_en[g] = ~gw_n | (~bwe_n & ~bw_n[g]);
  end

  always_comb begin
    if (cs_n) begin
      op_d = OP_IDLE;
    end else if (!gw_n || !bwe_n) begin
      op_d = OP_WRITE;
    end else begin
      op_d = OP_READ;
    end
  end

  assign cap_en = ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;
    end else begin
      op_q <= op_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= addr;
      wdata_q <= wdata;
      mask_q  <= lane_en;
    end
  end
endmodule

// File: rtl/sram_store.sv
module sram_store
  import sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int L  = 4,
  parameter int LW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_op_e          op_q,
  input  logic [AW-1:0]     addr_q,
  input  logic [L*LW-1:0]   wdata_q,
  input  logic [L-1:0]      mask_q,
  output logic [L*LW-1:0]   rd_word
);
  localparam int DW    = L * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // One-entry posted write buffer
  logic          pend_vld;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic [L-1:0]  pend_mask;

  logic          is_wr;
  logic          commit_en;
  logic          hit;
  logic [DW-1:0] arr_word;

  assign is_wr     = (op_q == OP_WRITE);
  assign commit_en = is_wr & pend_vld;
  assign hit       = pend_vld & (pend_addr == addr_q);
  assign arr_word  = mem[addr_q];

  // Buffered lanes override the array on an address match
  for (genvar g = 0; g < L; g++) begin : g_merge
    assign rd_word[g*LW +: LW] = (hit && pend_mask[g]) ? pend_data[g*LW +: LW]
                                                       : arr_word[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (commit_en) begin
      for (int i = 0; i < L; i++) begin
        if (pend_mask[i]) begin
          mem[pend_addr][i*LW +: LW] <= pend_data[i*LW +: LW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
    end else if (is_wr) begin
      pend_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (is_wr) begin
      pend_addr <= addr_q;
      pend_data <= wdata_q;
      pend_mask <= mask_q;
    end
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sram_op_e      op_q,
  input  logic [DW-1:0] rd_word,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          drv_q, drv_d;
  logic          idle_q, idle_d;
  logic          load_en;
  logic [DW-1:0] out_q;

  always_comb begin
    drv_d   = drv_q;
    idle_d  = 1'b0;
    load_en = 1'b0;
    unique case (op_q)
      OP_READ: begin
        drv_d   = 1'b1;
        load_en = 1'b1;
      end
      OP_WRITE: begin
        drv_d = 1'b0;
      end
      default: begin
        // Second consecutive idle stage releases the output
        idle_d = 1'b1;
        if (idle_q) begin
          drv_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      drv_q  <= drv_d;
      idle_q <= idle_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      out_q <= rd_word;
    end
  end

  assign rvalid = drv_q & ~oe_n;
  assign rdata  = rvalid ? out_q : '0;
endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
  import sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int L  = 4,
  parameter int LW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [AW-1:0]     addr,
  input  logic [L*LW-1:0]   wdata,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [L-1:0]      bw_n,
  input  logic              oe_n,
  output logic [L*LW-1:0]   rdata,
  output logic              rvalid
);
  localparam int DW = L * LW;

  sram_op_e      op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [L-1:0]  mask_q;
  logic [DW-1:0] rd_word;

  sram_in_stage #(.AW(AW), .L(L), .LW(LW)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .addr    (addr),
    .wdata   (wdata),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .mask_q  (mask_q)
  );

  sram_store #(.AW(AW), .L(L), .LW(LW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .mask_q  (mask_q),
    .rd_word (rd_word)
  );

  sram_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_q    (op_q),
    .rd_word (rd_word),
    .oe_n    (oe_n),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );
endmodule

// File: rtl/sync_sram_core_chk.sv
module sync_sram_core_chk #(
  parameter int L  = 4,
  parameter int LW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            gw_n,
  input logic            bwe_n,
  input logic            oe_n,
  input logic [L*LW-1:0] rdata,
  input logic            rvalid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !rvalid);

  assert_read_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && gw_n && bwe_n) |-> ##2 (rvalid || oe_n));

  assert_oe_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rvalid && rdata == '0));

  assert_double_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> ##2 !rvalid);

  assert_write_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (!gw_n || !bwe_n)) |-> ##2 !rvalid);
endmodule

bind sync_sram_core sync_sram_core_chk #(.L(L), .LW(LW)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .gw_n   (gw_n),
  .bwe_n  (bwe_n),
  .oe_n   (oe_n),
  .rdata  (rdata),
  .rvalid (rvalid)
);

// File: tb/test_sync_sram_core.sv
module test_sync_sram_core;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int L     = 4;
  localparam int LW    = 9;
  localparam int DW    = L * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, gw_n, bwe_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [L-1:0]  bw_n;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #(CLK_P/2) clk = ~clk;

  sync_sram_core #(.AW(AW), .L(L), .LW(LW)) i_sync_sram_core (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wdata(wdata),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // Requirement-level model
  logic [DW-1:0] mmem [DEPTH];
  int            m_op = 0;          // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_addr = '0;
  bit            m_idle_prev = 1'b1;
  bit            exp_drv = 1'b0;
  logic [DW-1:0] exp_out = '0;
  string         tg1 = "R1";
  string         tg2 = "R1";

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic check(string tag, logic [DW-1:0] act_d, logic [DW-1:0] exp_d,
                       bit act_v, bit exp_v);
    n_chk++;
    if (act_d !== exp_d || act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, act_v, act_d, exp_v, exp_d);
    end
  endtask

  task automatic check_port(string tag);
    bit            ev;
    logic [DW-1:0] ed;
    ev = exp_drv && !oe_n;
    ed = ev ? exp_out : '0;
    check(tag, rdata, ed, rvalid, ev);
  endtask

  task automatic step(string tag, bit c_n, bit g_n, bit b_n, logic [L-1:0] s_n,
                      logic [AW-1:0] a, logic [DW-1:0] d, bit probe = 1'b0);
    @(negedge clk);
    check_port(tg2);
    if (probe) begin
      oe_n = 1'b1; #1;
      check_port("R7");
      oe_n = 1'b0; #1;
      check_port("R7");
    end
    cs_n = c_n; gw_n = g_n; bwe_n = b_n; bw_n = s_n; addr = a; wdata = d;
    @(posedge clk);
    // output stage fed by the previously captured cycle
    if (m_op == 1) begin
      exp_out = mmem[m_addr];
      exp_drv = 1'b1;
    end else if (m_op == 2) begin
      exp_drv = 1'b0;
    end else if (m_idle_prev) begin
      exp_drv = 1'b0;
    end
    m_idle_prev = (m_op == 0);
    // capture of the current cycle
    if (!c_n) begin
      m_addr = a;
      if (!g_n || !b_n) begin
        m_op = 2;
        for (int i = 0; i < L; i++) begin
          if (!g_n || (!b_n && !s_n[i])) mmem[a][i*LW +: LW] = d[i*LW +: LW];
        end
      end else begin
        m_op = 1;
      end
    end else begin
      m_op = 0;
    end
    tg2 = tg1;
    tg1 = tag;
  endtask

  task automatic rd(string tag, logic [AW-1:0] a, bit probe = 1'b0);
    step(tag, 1'b0, 1'b1, 1'b1, '1, a, rnd_word(), probe);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b1, 1'b1, 1'b1, '1, '0, '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    oe_n = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", rdata, '0, rvalid, 1'b0);
    rst_n = 1'b1;

    // R2: global write fills every word regardless of the other strobes
    for (int a = 0; a < DEPTH; a++) begin
      step("R2", 1'b0, 1'b0, 1'($urandom()), L'($urandom()), AW'(a), rnd_word());
    end
    for (int a = 0; a < DEPTH; a++) rd("R5", AW'(a));

    // R3: per-lane writes, then strobes without byte-write enable
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] a = AW'($urandom());
      step("R3", 1'b0, 1'b1, 1'b0, L'($urandom()), a, rnd_word());
      idle("R3");
      rd("R3", a);
      step("R3", 1'b0, 1'b1, 1'b1, L'($urandom()), a, rnd_word());
    end

    // R4: byte-write enable with no lane strobe
    step("R4", 1'b0, 1'b1, 1'b0, '1, AW'(5), rnd_word());
    rd("R4", AW'(5));
    idle("R4");

    // R6: read right after a write, including stacked partial writes
    step("R6", 1'b0, 1'b1, 1'b0, 4'b1010, AW'(9), rnd_word());
    rd("R6", AW'(9));
    step("R6", 1'b0, 1'b1, 1'b0, 4'b1110, AW'(9), rnd_word());
    step("R6", 1'b0, 1'b1, 1'b0, 4'b0111, AW'(9), rnd_word());
    rd("R6", AW'(9));
    step("R6", 1'b0, 1'b0, 1'b1, '1, AW'(10), rnd_word());
    rd("R6", AW'(10));
    rd("R6", AW'(9));

    // R8: single deselect holds, double deselect releases
    rd("R8", AW'(3));
    idle("R8");
    rd("R8", AW'(4));
    idle("R8");
    idle("R8");
    idle("R8");

    // R9: write after read releases the output
    rd("R9", AW'(6));
    step("R9", 1'b0, 1'b0, 1'b1, '1, AW'(7), rnd_word());
    rd("R9", AW'(7));

    // R10: write attempts while deselected
    step("R10", 1'b1, 1'b0, 1'b0, '0, AW'(12), rnd_word());
    step("R10", 1'b1, 1'b1, 1'b0, '0, AW'(12), rnd_word());
    rd("R10", AW'(12));
    idle("R10");

    // R7: output enable masks without a clock edge
    rd("R7", AW'(20));
    rd("R7", AW'(21));
    rd("R7", AW'(22), 1'b1);
    idle("R7");

    // Mixed random traffic on a narrow address window
    for (int k = 0; k < 3000; k++) begin
      bit            c_n = ($urandom_range(0, 99) < 15);
      bit            g_n = ($urandom_range(0, 99) >= 20);
      bit            b_n = ($urandom_range(0, 99) >= 35);
      logic [AW-1:0] a   = AW'($urandom_range(0, 7));
      string         tg;
      if (c_n)              tg = "R8";
      else if (g_n && b_n)  tg = "R5";
      else                  tg = "R6";
      oe_n = ($urandom_range(0, 99) < 10);
      step(tg, c_n, g_n, b_n, L'($urandom()), a, rnd_word());
    end
    oe_n = 1'b0;
    idle("R8");
    idle("R8");
    idle("R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule